// File: doc/BRIEF.md
# Delay-Line Hit Time-Stamp Encoder

This block is the digital back end of a time-tagging time-to-digital converter. A locked delay line spans exactly one reference clock period and is divided into `N_TAPS` equal steps. When a hit arrives, all tap states are latched at the same moment. That latched word comes into this block together with a one-cycle `hit_valid` strobe. The word is roughly a thermometer pattern. The position where it steps from one to zero gives the elapsed time since the reference rising edge, in units of one tap delay.

The block cleans up single-tap bubbles with a three-tap majority vote. It then finds the one-to-zero step, treating the line as circular because tap N and tap 0 carry the same phase. A free-running coarse counter counts reference periods, and the located step position is appended to it. One timestamp with an error flag comes out per hit, so a stream of hits is placed on a common time scale. A hit that falls late in a reference period takes its coarse value from a copy of the counter that lags by one period. This keeps the coarse field from being one too high.

Top module: `tdc_tag_enc`

## Requirements
- R1: While `rst` is high at a clock edge, `ts_valid`, `ts_err` and `ts_word` are cleared to zero after that edge, and the coarse counter restarts so that the first clock edge with `rst` low samples a count of 0.
- R2: `ts_valid` is high in exactly the cycle after each edge that samples `hit_valid` high, and low otherwise. `ts_word` and `ts_err` keep their last value when no hit is sampled.
- R3: Bit i of `hit_taps` is 1 when the reference edge has passed tap i. The fine code is the smallest i in 0..N_TAPS-1 for which the corrected bit i is 0 and the corrected bit (i-1) mod N_TAPS is 1. A pattern of k ones followed by zeros gives k, and a pattern with bit N_TAPS-1 at 1 and bit 0 at 0 gives 0.
- R4: Before the search, corrected bit i is the majority of raw bits i-1, i and i+1, with indices taken mod N_TAPS. A single isolated 0 among ones, or a single isolated 1 among zeros, therefore does not change the fine code.
- R5: When the corrected word is all ones or all zeros, the timestamp carries `ts_err` = 1 and a fine code of 0. Otherwise `ts_err` = 0.
- R6: The coarse counter is `COARSE_W` bits wide. It advances by one on every clock edge with `rst` low and wraps modulo 2^COARSE_W.
- R7: Let C be the counter value sampled at the edge that takes the hit. The coarse field is C when the fine code is below N_TAPS/2, and (C-1) mod 2^COARSE_W when the fine code's MSB is set. `N_TAPS` must be a power of two.
- R8: `ts_word` is {coarse, fine}. The fine code occupies the low clog2(N_TAPS) bits and the coarse field occupies the upper `COARSE_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the coarse counter |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | One-cycle strobe marking a latched tap word |
| hit_taps | input | N_TAPS | Latched delay-line tap states |
| ts_valid | output | 1 | Timestamp present this cycle |
| ts_err | output | 1 | Tap word held no one-to-zero step |
| ts_word | output | COARSE_W+clog2(N_TAPS) | Timestamp {coarse, fine} |

## Verification
The hardest case to reach from the ports is a late-period hit taken when the coarse counter has just wrapped. In that case the lagging counter copy must read all ones, while the live count reads zero. The bench drives such a hit on the very first cycle after reset. The bench is instantiated with a narrow coarse counter, and random idle gaps between hits carry the count across its wrap many times. Rotated thermometer words with single flipped taps cover both the circular step at tap 0 and the bubble vote at the ends of the line.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    // Two-of-three vote used to suppress single-tap bubbles.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Circular neighbour indices on the delay line (tap N aliases tap 0).
    function automatic int tap_below(input int i, input int n);
        return (i == 0) ? n - 1 : i - 1;
    endfunction

    function automatic int tap_above(input int i, input int n);
        return (i == n - 1) ? 0 : i + 1;
    endfunction

    typedef enum logic {
        STAMP_OK  = 1'b0,
        STAMP_BAD = 1'b1
    } stamp_stat_e;

endpackage

// File: rtl/tdc_bubble_fix.sv
module tdc_bubble_fix #(
    parameter int N_TAPS = 32
) (
    input  logic [N_TAPS-1:0] raw,
    output logic [N_TAPS-1:0] clean
);
    import tdc_pkg::*;

    for (genvar g = 0; g < N_TAPS; g++) begin : g_vote
        localparam int LO = tap_below(g, N_TAPS);
        localparam int HI = tap_above(g, N_TAPS);
        assign clean[g] = maj3(raw[LO], raw[g], raw[HI]);
    end

    // R4: a solid word passes the vote unchanged
    always_comb begin
        if (&raw)  a_r4_solid_ones:  assert (&clean);
        if (~|raw) a_r4_solid_zeros: assert (~|clean);
    end

endmodule

// File: rtl/tdc_edge_find.sv
module tdc_edge_find #(
    parameter int N_TAPS = 32,
    parameter int FW     = $clog2(N_TAPS)
) (
    input  logic [N_TAPS-1:0] therm,
    output logic [FW-1:0]     pos,
    output logic              found
);
    logic [FW-1:0] pos_below;

    // Scan from the top so the lowest matching tap wins.
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = N_TAPS - 1; i >= 0; i--) begin
            if (therm[(i == 0) ? N_TAPS - 1 : i - 1] && !therm[i]) begin
                pos   = FW'(i);
                found = 1'b1;
            end
        end
    end

    assign pos_below = pos - 1'b1;   // wraps mod N_TAPS (power of two)

    always_comb begin
        // R3: the reported position really is a one-to-zero step
        if (found) a_r3_step_at_pos: assert (!therm[pos] && therm[pos_below]);
        // R5: no step only for a solid word
        if (!found) a_r5_solid_when_none: assert ((&therm) || (~|therm));
    end

endmodule

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
    parameter int COARSE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    output logic [COARSE_W-1:0] cnt,
    output logic [COARSE_W-1:0] cnt_lag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cnt_lag <= '1;
        end else begin
            cnt     <= cnt + 1'b1;
            cnt_lag <= cnt;
        end
    end

    // R6: one step per clock, modulo the width
    a_r6_coarse_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt == COARSE_W'($past(cnt) + 1'b1));

    // R7: lagging copy trails the live count by exactly one period
    a_r7_lag_copy: assert property (@(posedge clk) disable iff (rst)
        cnt_lag == COARSE_W'(cnt - 1'b1));

endmodule

// File: rtl/tdc_tag_enc.sv
module tdc_tag_enc #(
    parameter int N_TAPS   = 32,
    parameter int COARSE_W = 16,
    localparam int FW      = $clog2(N_TAPS),
    localparam int TW      = COARSE_W + FW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_valid,
    input  logic [N_TAPS-1:0] hit_taps,
    output logic              ts_valid,
    output logic              ts_err,
    output logic [TW-1:0]     ts_word
);
    import tdc_pkg::*;

    logic [N_TAPS-1:0]   clean;
    logic [FW-1:0]       pos;
    logic                found;
    logic [COARSE_W-1:0] cnt, cnt_lag, coarse_sel;
    logic [FW-1:0]       fine;
    stamp_stat_e         stat;

    tdc_bubble_fix #(.N_TAPS(N_TAPS)) u_fix (
        .raw   (hit_taps),
        .clean (clean)
    );

    tdc_edge_find #(.N_TAPS(N_TAPS), .FW(FW)) u_find (
        .therm (clean),
        .pos   (pos),
        .found (found)
    );

    tdc_coarse_ctr #(.COARSE_W(COARSE_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .cnt_lag (cnt_lag)
    );

    // Late-period hits take the lagging counter copy (R7).
    always_comb begin
        stat       = found ? STAMP_OK : STAMP_BAD;
        fine       = (stat == STAMP_OK) ? pos : '0;
        coarse_sel = fine[FW-1] ? cnt_lag : cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_valid <= 1'b0;
            ts_err   <= 1'b0;
            ts_word  <= '0;
        end else begin
            ts_valid <= hit_valid;
            if (hit_valid) begin
                ts_err  <= (stat == STAMP_BAD);
                ts_word <= {coarse_sel, fine};
            end
        end
    end

    // R2: one timestamp per sampled hit, none otherwise
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        hit_valid |=> ts_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |=> !ts_valid);
    a_r2_hold_word: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |=> $stable(ts_word) && $stable(ts_err));
    // R5: an error stamp carries a zero fine field
    a_r5_err_fine_zero: assert property (@(posedge clk) disable iff (rst)
        ts_valid && ts_err |-> ts_word[FW-1:0] == '0);

endmodule

// File: tb/tdc_tag_enc_test.sv
module tdc_tag_enc_test;
    localparam int N  = 32;
    localparam int CW = 8;
    localparam int FW = $clog2(N);
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hit_valid = 1'b0;
    logic [N-1:0]      hit_taps = '0;
    logic              ts_valid, ts_err;
    logic [CW+FW-1:0]  ts_word;

    int checks = 0;
    int errors = 0;
    int mcount = 0;
    logic [CW+FW-1:0] last_word = '0;

    tdc_tag_enc #(.N_TAPS(N), .COARSE_W(CW)) uut (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_taps(hit_taps),
        .ts_valid(ts_valid), .ts_err(ts_err), .ts_word(ts_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (!rst) mcount <= mcount + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] m_fix(input logic [N-1:0] r);
        logic [N-1:0] c;
        for (int i = 0; i < N; i++) begin
            int s;
            s = int'(r[(i + N - 1) % N]) + int'(r[i]) + int'(r[(i + 1) % N]);
            c[i] = (s >= 2);
        end
        return c;
    endfunction

    function automatic int m_fine(input logic [N-1:0] c);
        for (int i = 0; i < N; i++)
            if (c[(i + N - 1) % N] && !c[i]) return i;
        return -1;
    endfunction

    function automatic logic [N-1:0] thermo(input int k, input int rot);
        logic [N-1:0] b;
        b = '0;
        for (int i = 0; i < N; i++) if (i < k) b[i] = 1'b1;
        if (rot == 0) return b;
        return (b << rot) | (b >> (N - rot));
    endfunction

    // Drive one hit just after a falling edge; check at the next falling edge.
    task automatic hit(input logic [N-1:0] t, input bit keep, input string req);
        int f;
        bit e;
        logic [CW-1:0] c, ec;
        logic [CW+FW-1:0] ew;
        hit_valid = 1'b1;
        hit_taps  = t;
        c = CW'(mcount);
        f = m_fine(m_fix(t));
        e = (f < 0);
        if (e) f = 0;
        ec = (f >= N/2) ? CW'(c - 1'b1) : c;
        ew = {ec, FW'(f)};
        @(negedge clk);
        if (!keep) hit_valid = 1'b0;
        chk(ts_valid == 1'b1, "R2", "ts_valid after hit", 32'(ts_valid), 1);
        chk(ts_err == e, (e ? "R5" : req), "ts_err", 32'(ts_err), 32'(e));
        chk(ts_word == ew, req, "ts_word", 32'(ts_word), 32'(ew));
        last_word = ts_word;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(ts_valid == 1'b0, "R2", "ts_valid idle", 32'(ts_valid), 0);
            chk(ts_word == last_word, "R2", "ts_word held", 32'(ts_word), 32'(last_word));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_7DC1));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ts_valid == 1'b0, "R1", "ts_valid in reset", 32'(ts_valid), 0);
        chk(ts_err == 1'b0, "R1", "ts_err in reset", 32'(ts_err), 0);
        chk(ts_word == '0, "R1", "ts_word in reset", 32'(ts_word), 0);
        rst = 1'b0;

        // R7: late hit at count 0 must read the wrapped lag copy (all ones)
        hit(thermo(20, 0), 1'b0, "R7");
        idle(2);
        // R3: plain thermometer words
        hit(thermo(1, 0), 1'b0, "R3");
        hit(thermo(31, 0), 1'b0, "R3");
        // R7: boundary either side of half period, back to back (R6 steps)
        hit(thermo(15, 0), 1'b1, "R7");
        hit(thermo(16, 0), 1'b1, "R7");
        hit(thermo(15, 0), 1'b0, "R6");
        idle(1);
        // R3: circular step at tap 0
        hit(~thermo(9, 0), 1'b0, "R3");
        // R4: isolated bubbles
        hit(thermo(10, 0) & ~(32'h1 << 4), 1'b0, "R4");
        hit(thermo(10, 0) | (32'h1 << 20), 1'b0, "R4");
        hit(thermo(10, 0) | (32'h1 << 31), 1'b0, "R4");
        // R5: solid words
        hit('1, 1'b0, "R5");
        hit('0, 1'b0, "R5");
        hit(32'h0000_0008, 1'b0, "R5");
        idle(1);

        // Random mix; gaps carry the counter through several wraps (R6, R8)
        for (int n = 0; n < 400; n++) begin
            int kind;
            logic [N-1:0] t;
            kind = $urandom % 4;
            t = thermo(1 + ($urandom % (N - 1)), $urandom % N);
            if (kind == 1) t[$urandom % N] ^= 1'b1;
            if (kind == 2) t = $urandom;
            hit(t, ($urandom % 3) == 0, "R8");
            if (!hit_valid) idle($urandom % 4);
        end
        hit_valid = 1'b0;
        idle(1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule